// File: doc/BRIEF.md
# Dual-Port GPIO Register Bank with Input Polarity Control

This block holds the registers behind a sixteen-pin general-purpose I/O expander. The pins are split into two byte-wide ports. Each port has four registers: a sampled input register, a stored output register, a polarity mask that applies to input reads, and a direction mask. A serial target interface (outside this block) turns bus transactions into byte-wide write and read strobes with a three-bit register address. The bank decodes those strobes, keeps the registers, and drives per-pin output-enable and output-value signals to the pad ring.

Pin levels go through a two-stage synchroniser and then into the input register. The input register follows the pins whether a pin is an input or an output. An input read returns the sampled levels XORed with the polarity mask. An output read returns the stored flip-flop value and never the pin. A read strobe captures the selected byte into a holding register. That byte stays fixed while the serial interface shifts it out, so pin activity after the strobe only shows in the next read.

Top module: `gpio_regbank`

## Requirements
- R1: The address is decoded as {kind[1:0], port}. Bit 0 selects the port (0 = pins 7..0, 1 = pins 15..8). Bits 2:1 select the register kind: 0 input, 1 output, 2 polarity, 3 direction.
- R2: After reset every output register reads 0xFF, every polarity register reads 0x00 and every direction register reads 0xFF. `pin_oe` and `pin_out` are all zero.
- R3: A direction bit of 0 sets `pin_oe` to 1 and drives `pin_out` from the output register bit. A direction bit of 1 sets `pin_oe` to 0 and holds `pin_out` at 0, whatever the output register bit is.
- R4: A write with `bus_wr` high loads `bus_wdata` into the addressed output, polarity or direction register at that clock edge. The new value shows on `pin_oe`/`pin_out` right after that edge.
- R5: The input register holds the level that `pin_in` had three clock edges earlier (two synchroniser stages plus the register). This holds for both pin directions.
- R6: A write to address 0 or 1 (input kind) changes no register. Input reads keep following the pins.
- R7: An input read returns the input register XORed with that port's polarity register.
- R8: An output read returns the stored output register value, even when the pin is not driven.
- R9: `bus_rdata` loads at the edge where `bus_rd` is high and holds until the next read strobe. A pin change after the strobe shows only in a later read.
- R10: A write to one port leaves the registers of the other port unchanged.
- R11: When `bus_rd` and `bus_wr` hit the same address in one cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe from the serial target |
| bus_rd | input | 1 | Read capture strobe from the serial target |
| bus_addr | input | 3 | Register address {kind, port} |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Captured read data byte |
| pin_in | input | 16 | Pin levels from the pads |
| pin_oe | output | 16 | Per-pin driver enable |
| pin_out | output | 16 | Per-pin drive value |

## Verification
Two functions can land in the same cycle: a read capture and a register write to the same address. The serial target can issue both at once when it turns the bus around. The bench raises both strobes in one cycle on an output register. It expects the captured byte to be the old contents, and a following read to return the new byte. A second overlap, a pin change landing just after a read strobe, is judged by checking that the held byte is unchanged until the next strobe.

// File: rtl/gpio_pkg.sv
// Shared definitions for the GPIO register bank.
// Assumes the address is {kind, port} with the kind in the two upper bits.
package gpio_pkg;
    typedef enum logic [1:0] {
        KIND_IN  = 2'd0,
        KIND_OUT = 2'd1,
        KIND_POL = 2'd2,
        KIND_DIR = 2'd3
    } reg_kind_e;
endpackage

// File: rtl/gpio_sync.sv
// Brings asynchronous pin levels into the clock domain.
// Two synchroniser flops feed the input register, so the register lags the pins by three edges.
// Assumes each pin is stable long enough to be seen; no glitch filtering.
module gpio_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_async,
    output logic [W-1:0] in_q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [1:0]   age_q;

    // Purpose: synchronise pins and load the input register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            in_q   <= '0;
        end else begin
            meta_q <= pin_async;
            sync_q <= meta_q;
            in_q   <= sync_q;
        end
    end

    // Purpose: count edges since reset, saturating, so the assertion looks back only over valid history.
    always_ff @(posedge clk) begin
        if (!rst_n)           age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    // R5: the input register follows the pins with a three-edge lag
    p_in_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) |-> (in_q == $past(pin_async, 3)));
endmodule

// File: rtl/gpio_port.sv
// Register set for one byte-wide port: output, polarity and direction.
// Assumes wr_en is already qualified with this port's select.
// Writes of the input kind are dropped.
module gpio_port
    import gpio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  reg_kind_e    wr_kind,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] out_q,
    output logic [W-1:0] pol_q,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] oe,
    output logic [W-1:0] drive
);
    // Purpose: hold the writable registers and apply write strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '1;
            pol_q <= '0;
            dir_q <= '1;
        end else if (wr_en) begin
            case (wr_kind)
                KIND_OUT: out_q <= wdata;
                KIND_POL: pol_q <= wdata;
                KIND_DIR: dir_q <= wdata;
                default:  ;
            endcase
        end
    end

    // Purpose: enable drivers for output pins and keep undriven pins at zero.
    always_comb begin
        oe    = ~dir_q;
        drive = out_q & ~dir_q;
    end

    // R2: defaults present on the first cycle after reset
    p_reset_dflt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (out_q == '1 && pol_q == '0 && dir_q == '1));
    // R4: an output write lands at the strobe edge
    p_out_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == KIND_OUT) |=> (out_q == $past(wdata)));
    // R6: an input-kind write leaves every register alone
    p_in_write_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == KIND_IN) |=> ($stable(out_q) && $stable(pol_q) && $stable(dir_q)));
endmodule

// File: rtl/gpio_regbank.sv
// Two-port GPIO register bank behind a byte-wide register bus.
// Decodes {kind, port} addresses, keeps per-port registers, drives pin enables and values,
// and captures read data on the read strobe.
// Assumes NUM_PORTS is a power of two, at least 2.
module gpio_regbank
    import gpio_pkg::*;
#(
    parameter int PORT_W    = 8,
    parameter int NUM_PORTS = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_wr,
    input  logic                          bus_rd,
    input  logic [$clog2(NUM_PORTS)+1:0]  bus_addr,
    input  logic [PORT_W-1:0]             bus_wdata,
    output logic [PORT_W-1:0]             bus_rdata,
    input  logic [PORT_W*NUM_PORTS-1:0]   pin_in,
    output logic [PORT_W*NUM_PORTS-1:0]   pin_oe,
    output logic [PORT_W*NUM_PORTS-1:0]   pin_out
);
    localparam int PSEL_W = $clog2(NUM_PORTS);
    localparam int ADDR_W = PSEL_W + 2;
    localparam int PINS   = PORT_W * NUM_PORTS;

    reg_kind_e         sel_kind;
    logic [PSEL_W-1:0] sel_port;
    logic [PINS-1:0]   in_all;
    logic [PORT_W-1:0] in_a  [NUM_PORTS];
    logic [PORT_W-1:0] out_a [NUM_PORTS];
    logic [PORT_W-1:0] pol_a [NUM_PORTS];
    logic [PORT_W-1:0] dir_a [NUM_PORTS];
    logic [PORT_W-1:0] rd_mux;

    // Purpose: split the address into register kind and port select.
    always_comb begin
        sel_kind = reg_kind_e'(bus_addr[ADDR_W-1 -: 2]);
        sel_port = bus_addr[PSEL_W-1:0];
    end

    gpio_sync #(.W(PINS)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (pin_in),
        .in_q      (in_all)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic wr_hit;
        // Purpose: qualify the write strobe with this port's select.
        always_comb wr_hit = bus_wr && (sel_port == PSEL_W'(p));
        // Purpose: expose this port's slice of the input register.
        always_comb in_a[p] = in_all[p*PORT_W +: PORT_W];

        gpio_port #(.W(PORT_W)) u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_hit),
            .wr_kind (sel_kind),
            .wdata   (bus_wdata),
            .out_q   (out_a[p]),
            .pol_q   (pol_a[p]),
            .dir_q   (dir_a[p]),
            .oe      (pin_oe[p*PORT_W +: PORT_W]),
            .drive   (pin_out[p*PORT_W +: PORT_W])
        );
    end

    // Purpose: select the addressed register; input reads go through the polarity mask.
    always_comb begin
        case (sel_kind)
            KIND_IN:  rd_mux = in_a[sel_port] ^ pol_a[sel_port];
            KIND_OUT: rd_mux = out_a[sel_port];
            KIND_POL: rd_mux = pol_a[sel_port];
            default:  rd_mux = dir_a[sel_port];
        endcase
    end

    // Purpose: capture the read byte on the strobe and hold it while it is shifted out.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    // R9: read data holds between strobes
    p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
    // R7: input read is the sampled pins XOR polarity
    p_rd_in_pol_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel_kind == KIND_IN) |=>
            (bus_rdata == $past(in_a[sel_port] ^ pol_a[sel_port])));
    // R8, R11: output read returns the stored value from before any same-cycle write
    p_rd_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel_kind == KIND_OUT) |=> (bus_rdata == $past(out_a[sel_port])));
endmodule

// File: tb/tb_gpio_regbank.sv
`timescale 1ns/1ps
module tb_gpio_regbank;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr, bus_rd;
    logic [2:0]  bus_addr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic [15:0] pin_in;
    logic [15:0] pin_oe, pin_out;

    int checks = 0;
    int errors = 0;
    logic [7:0] rv;
    logic [7:0] out_m [2];
    logic [7:0] pol_m [2];
    logic [7:0] dir_m [2];

    always #10 clk = ~clk;

    gpio_regbank dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a[2:1] == 2'd1) out_m[a[0]] = d;
        if (a[2:1] == 2'd2) pol_m[a[0]] = d;
        if (a[2:1] == 2'd3) dir_m[a[0]] = d;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [15:0] exp_oe();
        return {~dir_m[1], ~dir_m[0]};
    endfunction
    function automatic logic [15:0] exp_out();
        return {out_m[1] & ~dir_m[1], out_m[0] & ~dir_m[0]};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        pin_in = 16'hA5C3;
        for (int p = 0; p < 2; p++) begin out_m[p] = 8'hFF; pol_m[p] = 8'h00; dir_m[p] = 8'hFF; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: reset state at the pins and in every register
        check("R2 pin_oe", pin_oe, 16'h0000);
        check("R2 pin_out", pin_out, 16'h0000);
        for (int a = 2; a < 8; a++) begin
            rd(3'(a), rv);
            check("R2 default", {8'h0, rv}, (a < 4 || a >= 6) ? 16'h00FF : 16'h0000);
        end

        // R1 R4 R10: output write to port 0 only
        wr(3'd2, 8'h3C);
        rd(3'd2, rv); check("R4 out0 readback", {8'h0, rv}, 16'h003C);
        rd(3'd3, rv); check("R10 out1 untouched", {8'h0, rv}, 16'h00FF);
        wr(3'd2, 8'h96);
        wr(3'd3, 8'h69);

        // R3: exhaustive direction sweep on both ports
        for (int p = 0; p < 2; p++) begin
            for (int d = 0; d < 256; d++) begin
                wr(3'(6 + p), 8'(d));
                check("R3 pin_oe", pin_oe, exp_oe());
                check("R3 pin_out", pin_out, exp_out());
            end
        end
        wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);

        // R8: output readback is the flip-flop while pins are undriven
        rd(3'd2, rv); check("R8 out0 stored", {8'h0, rv}, 16'h0096);
        rd(3'd3, rv); check("R8 out1 stored", {8'h0, rv}, 16'h0069);
        check("R8 pins undriven", pin_out, 16'h0000);

        // R5: exhaustive pin sweep with ports as outputs (input still tracks pins)
        wr(3'd6, 8'h00); wr(3'd7, 8'h00);
        for (int v = 0; v < 256; v++) begin
            pin_in = {~8'(v), 8'(v)};
            settle();
            rd(3'd0, rv); check("R5 in0", {8'h0, rv}, {8'h0, 8'(v)});
            rd(3'd1, rv); check("R5 in1", {8'h0, rv}, {8'h0, ~8'(v)});
        end

        // R7: exhaustive polarity sweep on both ports
        pin_in = 16'hC35A;
        settle();
        for (int p = 0; p < 2; p++) begin
            for (int v = 0; v < 256; v++) begin
                wr(3'(4 + p), 8'(v));
                rd(3'(p), rv);
                check("R7 polarity", {8'h0, rv}, {8'h0, pin_in[p*8 +: 8] ^ 8'(v)});
            end
        end
        wr(3'd4, 8'h0F); wr(3'd5, 8'hF0);

        // R6: input-kind writes change nothing
        wr(3'd0, 8'h00); wr(3'd1, 8'h00);
        for (int a = 2; a < 8; a++) begin
            logic [7:0] e;
            e = (a[2:1] == 2'd1) ? out_m[a[0]] : (a[2:1] == 2'd2) ? pol_m[a[0]] : dir_m[a[0]];
            rd(3'(a), rv); check("R6 other regs kept", {8'h0, rv}, {8'h0, e});
        end
        rd(3'd0, rv); check("R6 in0 still tracks", {8'h0, rv}, 16'h0055);
        rd(3'd1, rv); check("R6 in1 still tracks", {8'h0, rv}, 16'h0033);

        // R9: held data unaffected by later pin changes until the next strobe
        rd(3'd0, rv);
        pin_in = 16'h1234;
        settle();
        check("R9 held byte", {8'h0, bus_rdata}, 16'h0055);
        rd(3'd0, rv); check("R9 next read", {8'h0, rv}, 16'h003B);

        // R11: read and write on the same output register in one cycle
        @(negedge clk);
        bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = 3'd3; bus_wdata = 8'h5A;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        check("R11 old value read", {8'h0, bus_rdata}, 16'h0069);
        out_m[1] = 8'h5A;
        check("R11 pins take new value", pin_out, exp_out());
        rd(3'd3, rv); check("R11 new value next", {8'h0, rv}, 16'h005A);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule